// File: doc/BRIEF.md
# SD Card Single-Block Data Phase Engine

This engine runs the data phase of one block transfer to or from an SD card in SPI mode. It starts once the controlling logic has issued the read or write command and seen it accepted. It does not drive the serial lines itself. It hands one byte at a time to an external 8-bit SPI exchange port (`xchg_go`, `xchg_tx`) and waits for that port to return the byte shifted in (`xchg_done`, `xchg_rx`). Chip select (`cs_n`) comes from the engine. The block length is a parameter. The default is 512 bytes, and setting it to 16 lets the same engine fetch the card-specific data register.

For a read, the engine holds chip select low and polls with 0xFF until the card returns the start token 0xFE. It then moves the block bytes onto a valid/ready output stream, in order. It clocks in the two CRC bytes and drops them. For a write, it sends 0xFE and then the bytes pulled from a valid/ready input stream. It sends two 0xFF bytes where the CRC would go, and then reads the data response token. If the token shows acceptance, the engine polls while the card returns 0x00 (busy) and stops at the first nonzero byte. If the token shows rejection, it skips the busy wait. Every transfer ends the same way: chip select goes high and one more 0xFF is exchanged. After that, a one-cycle `done` pulse carries the status code.

The states are IDLE, HUNT (start-token search), RDATA, RCRC, WTOK, WDATA, WCRC, WRESP, BUSY and TAIL. The transitions are:
- IDLE goes to WTOK or HUNT on `start`, depending on `is_write`.
- HUNT goes to RDATA on 0xFE, and to TAIL on timeout.
- RDATA goes to RCRC after the last byte.
- RCRC goes to TAIL after two bytes.
- WTOK goes to WDATA after one byte.
- WDATA goes to WCRC after the last byte.
- WCRC goes to WRESP after two bytes.
- WRESP goes to BUSY when the token is accepted, and to TAIL when it is rejected.
- BUSY goes to TAIL on a nonzero byte or on timeout.
- TAIL goes to IDLE after its exchange.

Top module: `sdx_block_engine`

## Requirements
- R1: After reset, `cs_n` is 1, and `xchg_go`, `done`, `rd_valid` and `wr_ready` are 0.
- R2: A read holds `cs_n` at 0 and exchanges 0xFF until the received byte is 0xFE.
- R3: After the token, a read exchanges exactly BLK_LEN bytes of 0xFF and presents each received byte on `rd_data`/`rd_valid`, in order. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds and no further exchange starts.
- R4: After the read data, two more 0xFF bytes are exchanged with `cs_n` at 0. Their received values never appear on the output stream.
- R5: A write sends 0xFE, then BLK_LEN bytes taken in order from `wr_data` when `wr_valid` and `wr_ready` are both 1, then two 0xFF bytes. No exchange starts while `wr_valid` is 0 in the data phase.
- R6: The byte received after the write CRC is accepted when its bits [4:0] equal 5'b00101. Any other value, 0x0B and 0x0D included, ends the transfer with status 1 (rejected) and no busy polling.
- R7: After acceptance, 0xFF is exchanged while the received byte is 0x00. The first nonzero byte ends the wait with status 0.
- R8: If TMO_POLLS consecutive polls fail in the token hunt or the busy wait, the transfer ends with status 2 (timeout).
- R9: Every transfer ends with exactly one 0xFF exchange with `cs_n` at 1. This is followed by a one-cycle `done` pulse with `status` set to 0 (ok), 1 (rejected) or 2 (timeout).
- R10: A `start` pulse while a transfer is running is ignored.
- R11: At most one exchange is outstanding: `xchg_go` is not raised again until `xchg_done` has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE) |
| is_write | input | 1 | 1 for write, 0 for read, sampled with `start` |
| cs_n | output | 1 | Card chip select, active low |
| xchg_go | output | 1 | Request one byte exchange on the SPI port |
| xchg_tx | output | 8 | Byte to send, valid with `xchg_go` |
| xchg_done | input | 1 | Exchange finished |
| xchg_rx | input | 8 | Byte received, valid with `xchg_done` |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | Outcome, valid with `done` |

## Verification
A wrong state or byte count shows at the exchange port on the very next byte. The bench's byte-level card model compares every `xchg_go` against an expected (chip select, byte) sequence, so a missing, extra or misplaced exchange is reported at that byte, not only at the end of the transfer. A miscounted timeout or a token decode error changes the length of the poll sequence and the status delivered with `done`. A flaw in stream handling shows within a cycle as a changed `rd_data` under backpressure, or as a write byte sent out of order.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,
        ST_RDATA,
        ST_RCRC,
        ST_WTOK,
        ST_WDATA,
        ST_WCRC,
        ST_WRESP,
        ST_BUSY,
        ST_TAIL
    } xfer_state_e;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_REJECT  = 2'd1,
        XS_TIMEOUT = 2'd2
    } xfer_status_e;

    localparam logic [7:0] BYTE_FILL   = 8'hFF;
    localparam logic [7:0] TOKEN_START = 8'hFE;
    localparam logic [7:0] RESP_MASK   = 8'h1F;
    localparam logic [7:0] RESP_ACCEPT = 8'h05;

endpackage

// File: rtl/sdx_counter.sv
module sdx_counter #(
    parameter int LIMIT = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end

    assign at_last = (q == W'(LIMIT - 1));

    // A count never runs past its limit (R3, R8)
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> q != '0);

endmodule

// File: rtl/sdx_resp_decode.sv
module sdx_resp_decode
    import sdx_pkg::*;
(
    input  logic [7:0] rx,
    output logic       is_start,
    output logic       accepted,
    output logic       nonzero
);
    assign is_start = (rx == TOKEN_START);
    assign accepted = ((rx & RESP_MASK) == RESP_ACCEPT);
    assign nonzero  = |rx;
endmodule

// File: rtl/sdx_block_engine.sv
module sdx_block_engine
    import sdx_pkg::*;
#(
    parameter int BLK_LEN   = 512,
    parameter int TMO_POLLS = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_write,
    output logic       cs_n,
    output logic       xchg_go,
    output logic [7:0] xchg_tx,
    input  logic       xchg_done,
    input  logic [7:0] xchg_rx,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       rd_ready,
    input  logic [7:0] wr_data,
    input  logic       wr_valid,
    output logic       wr_ready,
    output logic       done,
    output logic [1:0] status
);
    xfer_state_e  state_q, state_d;
    xfer_status_e stat_q, stat_d;
    logic         pend_q;
    logic         crc2_q;
    logic         ev;
    logic         blk_last, tmo_last;
    logic         blk_inc, tmo_inc, cnt_clr;
    logic         rx_start, rx_accept, rx_nonzero;
    logic         can_send;
    logic         in_data;

    assign ev      = pend_q && xchg_done;
    assign in_data = (state_q == ST_RDATA) || (state_q == ST_WDATA);
    assign cnt_clr = (state_q == ST_IDLE);
    assign blk_inc = ev && in_data && !blk_last;
    assign tmo_inc = ev && !tmo_last &&
                     (((state_q == ST_HUNT) && !rx_start) ||
                      ((state_q == ST_BUSY) && !rx_nonzero));

    sdx_resp_decode u_dec (
        .rx       (xchg_rx),
        .is_start (rx_start),
        .accepted (rx_accept),
        .nonzero  (rx_nonzero)
    );

    sdx_counter #(.LIMIT(BLK_LEN)) u_blk_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (blk_inc),
        .at_last (blk_last)
    );

    sdx_counter #(.LIMIT(TMO_POLLS)) u_tmo_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (tmo_inc),
        .at_last (tmo_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        stat_d  = stat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = is_write ? ST_WTOK : ST_HUNT;
                    stat_d  = XS_OK;
                end
            end
            ST_HUNT: begin
                if (ev) begin
                    if (rx_start) begin
                        state_d = ST_RDATA;
                    end else if (tmo_last) begin
                        state_d = ST_TAIL;
                        stat_d  = XS_TIMEOUT;
                    end
                end
            end
            ST_RDATA: if (ev && blk_last) state_d = ST_RCRC;
            ST_RCRC:  if (ev && crc2_q)   state_d = ST_TAIL;
            ST_WTOK:  if (ev)             state_d = ST_WDATA;
            ST_WDATA: if (ev && blk_last) state_d = ST_WCRC;
            ST_WCRC:  if (ev && crc2_q)   state_d = ST_WRESP;
            ST_WRESP: begin
                if (ev) begin
                    if (rx_accept) begin
                        state_d = ST_BUSY;
                    end else begin
                        state_d = ST_TAIL;
                        stat_d  = XS_REJECT;
                    end
                end
            end
            ST_BUSY: begin
                if (ev) begin
                    if (rx_nonzero) begin
                        state_d = ST_TAIL;
                    end else if (tmo_last) begin
                        state_d = ST_TAIL;
                        stat_d  = XS_TIMEOUT;
                    end
                end
            end
            ST_TAIL: if (ev) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stat_q  <= XS_OK;
        end else begin
            state_q <= state_d;
            stat_q  <= stat_d;
        end
    end

    // Outputs toward the exchange port and the write stream
    always_comb begin
        cs_n     = 1'b0;
        xchg_tx  = BYTE_FILL;
        can_send = 1'b1;
        wr_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cs_n     = 1'b1;
                can_send = 1'b0;
            end
            ST_RDATA, ST_RCRC: can_send = !rd_valid;
            ST_WTOK:           xchg_tx  = TOKEN_START;
            ST_WDATA: begin
                xchg_tx  = wr_data;
                can_send = wr_valid;
                wr_ready = !pend_q;
            end
            ST_TAIL: cs_n = 1'b1;
            default: ;
        endcase
        xchg_go = !pend_q && can_send;
    end

    // Exchange tracking, read stream register, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            crc2_q   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
            done     <= 1'b0;
            status   <= 2'd0;
        end else begin
            if (xchg_go) begin
                pend_q <= 1'b1;
            end else if (xchg_done) begin
                pend_q <= 1'b0;
            end
            if (ev && ((state_q == ST_RCRC) || (state_q == ST_WCRC))) begin
                crc2_q <= !crc2_q;
            end
            if (ev && (state_q == ST_RDATA)) begin
                rd_valid <= 1'b1;
                rd_data  <= xchg_rx;
            end else if (rd_valid && rd_ready) begin
                rd_valid <= 1'b0;
            end
            done <= ev && (state_q == ST_TAIL);
            if (ev && (state_q == ST_TAIL)) begin
                status <= stat_q;
            end
        end
    end

    // Read byte held under backpressure (R3)
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // One exchange in flight (R11)
    p_single_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_go |=> !xchg_go);

    // Write stream only while the card is selected (R5)
    p_wr_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !cs_n);

    // Completion only with the card released and a legal code (R9)
    p_done_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n && (status != 2'd3));

    // Chip select steady while a byte is in flight (R9)
    p_cs_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && !xchg_done |=> $stable(cs_n));

endmodule

// File: tb/sdx_block_engine_bench.sv
module sdx_block_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BLK        = 16;
    localparam int TMO        = 12;
    localparam int LAT        = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, is_write = 1'b0;
    logic       cs_n, xchg_go, xchg_done = 1'b0;
    logic [7:0] xchg_tx, xchg_rx = 8'hFF;
    logic [7:0] rd_data, wr_data = 8'h00;
    logic       rd_valid, rd_ready = 1'b1, wr_valid = 1'b0, wr_ready;
    logic       done;
    logic [1:0] status;

    sdx_block_engine #(.BLK_LEN(BLK), .TMO_POLLS(TMO)) u_sdx_block_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
        .cs_n(cs_n), .xchg_go(xchg_go), .xchg_tx(xchg_tx),
        .xchg_done(xchg_done), .xchg_rx(xchg_rx),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .done(done), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    logic [8:0] exp_q[$];
    logic [7:0] rx_q[$], rd_exp[$], rd_got[$], wr_src[$];
    int  done_cnt = 0;
    logic [1:0] last_status = 2'd0;
    bit  bp_on = 0, gap_on = 0, run_model = 0;
    int  cyc = 0, cd = 0;
    bit  rd_hs = 0, wr_hs = 0;
    logic [7:0] rd_cap = 8'h00;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ex(input bit cs, input logic [7:0] tx, input logic [7:0] rx);
        exp_q.push_back({cs, tx});
        rx_q.push_back(rx);
    endtask

    // Behavioural card and stream model, evaluated once per clock
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            xchg_done = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    xchg_done = 1'b1;
                    xchg_rx = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
                end
            end
            if (rd_hs) rd_got.push_back(rd_cap);
            if (wr_hs && wr_src.size() > 0) void'(wr_src.pop_front());
            rd_ready = !bp_on || (cyc % 3 != 0);
            wr_valid = (wr_src.size() > 0) && (!gap_on || (cyc % 4 != 1));
            wr_data  = (wr_src.size() > 0) ? wr_src[0] : 8'h00;
            #1;
            rd_hs  = rd_valid && rd_ready;
            rd_cap = rd_data;
            wr_hs  = wr_valid && wr_ready;
            if (run_model) begin
                if (rd_valid && !rd_ready && cd > 0)
                    check(0, "R3", "exchange while read byte pending", 1, 0);
                if (xchg_go) begin
                    check(cd == 0, "R11", "go while byte outstanding", cd, 0);
                    if (exp_q.size() == 0) begin
                        check(0, "R9", "unexpected exchange", {cs_n, xchg_tx}, 0);
                    end else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        check({cs_n, xchg_tx} == e, "R2/R4/R5/R7",
                              "exchanged cs_n,byte", {cs_n, xchg_tx}, e);
                    end
                    cd = LAT;
                end
                if (done) begin
                    done_cnt++;
                    last_status = status;
                end
            end
        end
    end

    task automatic run(input bit wr, input bit glitch, input int exp_stat, input string req);
        int d0;
        int guard;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; is_write = wr;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (done_cnt == d0 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (glitch && guard == 20) begin
                start = 1'b1; is_write = !wr;
            end else begin
                start = 1'b0;
            end
        end
        check(guard < 5000, req, "transfer completed", guard, 0);
        repeat (6) @(negedge clk);
        check(done_cnt == d0 + 1, "R10", "done pulse count", done_cnt - d0, 1);
        check(last_status == 2'(exp_stat), req, "status", last_status, exp_stat);
        check(exp_q.size() == 0, "R9", "exchanges missing", exp_q.size(), 0);
        check(cs_n == 1'b1, "R9", "cs_n idle after done", cs_n, 1);
        check(rd_got.size() == rd_exp.size(), "R3", "read byte count",
              rd_got.size(), rd_exp.size());
        for (int i = 0; i < rd_exp.size() && i < rd_got.size(); i++)
            check(rd_got[i] == rd_exp[i], "R3", "read byte", rd_got[i], rd_exp[i]);
        check(wr_src.size() == 0, "R5", "write bytes consumed", wr_src.size(), 0);
        exp_q.delete(); rx_q.delete(); rd_exp.delete(); rd_got.delete(); wr_src.delete();
    endtask

    task automatic build_write(input logic [7:0] resp);
        ex(0, 8'hFE, 8'hFF);
        for (int i = 0; i < BLK; i++) begin
            logic [7:0] d;
            d = 8'(i * 13 + 5);
            wr_src.push_back(d);
            ex(0, d, 8'hFF);
        end
        ex(0, 8'hFF, 8'hFF);
        ex(0, 8'hFF, 8'hFF);
        ex(0, 8'hFF, resp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
        check(xchg_go == 1'b0, "R1", "xchg_go", xchg_go, 0);
        check(done == 1'b0 && rd_valid == 1'b0 && wr_ready == 1'b0, "R1",
              "done/rd_valid/wr_ready", {done, rd_valid, wr_ready}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_model = 1;

        // R2 R3 R4: read, token after three polls, backpressure, CRC bytes look like data
        bp_on = 1;
        for (int i = 0; i < 3; i++) ex(0, 8'hFF, (i == 1) ? 8'hFC : 8'hFF);
        ex(0, 8'hFF, 8'hFE);
        for (int i = 0; i < BLK; i++) begin
            logic [7:0] d;
            d = 8'(i * 7 + 3);
            rd_exp.push_back(d);
            ex(0, 8'hFF, d);
        end
        ex(0, 8'hFF, 8'hFE);
        ex(0, 8'hFF, 8'h00);
        ex(1, 8'hFF, 8'hFF);
        run(0, 0, 0, "R4");
        bp_on = 0;

        // R8: read token timeout
        for (int i = 0; i < TMO; i++) ex(0, 8'hFF, (i % 2) ? 8'h00 : 8'hFF);
        ex(1, 8'hFF, 8'hFF);
        run(0, 0, 2, "R8");

        // R5 R6 R7: accepted write with gaps on the input stream and busy bytes
        gap_on = 1;
        build_write(8'hE5);
        for (int i = 0; i < 3; i++) ex(0, 8'hFF, 8'h00);
        ex(0, 8'hFF, 8'h01);
        ex(1, 8'hFF, 8'hFF);
        run(1, 0, 0, "R7");
        gap_on = 0;

        // R6: CRC-error token, no busy wait
        build_write(8'h0B);
        ex(1, 8'hFF, 8'h00);
        run(1, 0, 1, "R6");

        // R6: write-error token with high bits set
        build_write(8'hED);
        ex(1, 8'hFF, 8'h00);
        run(1, 0, 1, "R6");

        // R8: busy wait timeout
        build_write(8'h05);
        for (int i = 0; i < TMO; i++) ex(0, 8'hFF, 8'h00);
        ex(1, 8'hFF, 8'hFF);
        run(1, 0, 2, "R8");

        // R10: start pulse during a read is ignored
        ex(0, 8'hFF, 8'hFE);
        for (int i = 0; i < BLK; i++) begin
            rd_exp.push_back(8'(255 - i));
            ex(0, 8'hFF, 8'(255 - i));
        end
        ex(0, 8'hFF, 8'hAA);
        ex(0, 8'hFF, 8'h55);
        ex(1, 8'hFF, 8'hFF);
        run(0, 1, 0, "R10");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule